// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory with Broadcast Fallback

This block holds the sharing information for a set of memory lines in an N-node cache-coherent system. Each line owns one directory entry made of a small fixed number of sharer slots and a broadcast flag. Each slot has a valid flag and one node identifier of log2(N) bits. A read request from a node records that node as a sharer of the addressed line. A write request turns the entry's contents into a stream of target node identifiers, one per cycle on a valid/ready interface. The protocol engine then sends an invalidation or forward message to each of these nodes.

When a line gains more distinct sharers than it has slots, the entry stops tracking precise identities and raises its broadcast flag. The next write then targets every node in the system except the writer, whether or not that node holds a copy. When the write fan-out completes, the entry is reset so that it holds only the writer. The slot count is a parameter. With one slot the entry is a single pointer plus the broadcast flag. With zero slots nothing is stored, and every write targets all N-1 other nodes.

Top module: `dirlp_directory`

## Requirements
- R1: After reset, `req_ready` is 1, `msg_valid` and `fan_done` are 0, and every line's entry is empty, so a write to any line emits no target.
- R2: A read from a node that is not yet recorded, on a line whose broadcast flag is clear and which has a free slot, stores that node in the lowest-numbered free slot. A later write emits that node as a target.
- R3: A read from a node already held in a valid slot of the line changes nothing: the node is emitted once and does not use up a second slot.
- R4: A read from a new node while all slots of the line are valid sets the line's broadcast flag. The next write to the line emits every node 0..N-1 except the writer, which is N-1 targets.
- R5: The node that issued the write is never emitted as a target, even when it is a recorded sharer.
- R6: Targets of one write leave in strictly ascending node-identifier order, one per accepted transfer. While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and `msg_node` hold their values.
- R7: A write is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 until `fan_done` has pulsed. `fan_done` is 1 for exactly one cycle: the cycle after the last target is accepted, or the cycle after acceptance if there is no target. `req_ready` is 1 again in the following cycle.
- R8: After a write completes, the line holds only the writer, with the broadcast flag clear. A following write by a different node emits exactly the previous writer.
- R9: Entries of different lines are independent. A request to one line leaves every other line's targets unchanged.
- R10: With zero slots configured, every write emits all N-1 nodes other than the writer, no matter which reads came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_write | input | 1 | 1 = write (fan-out), 0 = read (add sharer) |
| req_line | input | $clog2(NUM_LINES) | Line whose entry is addressed |
| req_node | input | $clog2(NUM_NODES) | Requesting node |
| msg_valid | output | 1 | A target node is offered |
| msg_ready | input | 1 | Consumer takes the offered target |
| msg_node | output | $clog2(NUM_NODES) | Target node identifier |
| fan_done | output | 1 | One-cycle pulse ending a write's fan-out |

## Verification
The bench builds two instances with eight nodes and sixteen lines. One has two slots and the other has zero slots. The two-slot instance runs every one of the 256 reader subsets across rotating lines and writers. These subsets, with a duplicate re-read on alternate runs, reach every slot occupancy: empty, partial, full, overflowed into broadcast, and writer-is-sharer. The zero-slot instance is written by each of the eight possible writers. A repeating backpressure pattern on `msg_ready` exercises stalls in every fan-out.

// File: rtl/dirlp_pkg.sv
package dirlp_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FAN  = 1'b1
  } dir_state_e;

endpackage

// File: rtl/dirlp_entry_store.sv
module dirlp_entry_store #(
  parameter int NUM_NODES = 8,
  parameter int NUM_PTRS  = 2,
  parameter int NUM_LINES = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(NUM_LINES)-1:0]        rd_line,
  output logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0][$clog2(NUM_NODES)-1:0] rd_ptr,
  output logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0] rd_vld,
  output logic                                rd_bcast,
  input  logic                                wr_en,
  input  logic [$clog2(NUM_LINES)-1:0]        wr_line,
  input  logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0][$clog2(NUM_NODES)-1:0] wr_ptr,
  input  logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0] wr_vld,
  input  logic                                wr_bcast
);

  localparam int NODE_W = $clog2(NUM_NODES);
  localparam int SLOTS  = (NUM_PTRS > 0) ? NUM_PTRS : 1;

  generate
    if (NUM_PTRS > 0) begin : g_slots
      logic [SLOTS-1:0][NODE_W-1:0] ptr_q [NUM_LINES];
      logic [SLOTS-1:0]             vld_q [NUM_LINES];
      logic                         bc_q  [NUM_LINES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int l = 0; l < NUM_LINES; l++) begin
            ptr_q[l] <= '0;
            vld_q[l] <= '0;
            bc_q[l]  <= 1'b0;
          end
        end else if (wr_en) begin
          ptr_q[wr_line] <= wr_ptr;
          vld_q[wr_line] <= wr_vld;
          bc_q[wr_line]  <= wr_bcast;
        end
      end

      assign rd_ptr   = ptr_q[rd_line];
      assign rd_vld   = vld_q[rd_line];
      assign rd_bcast = bc_q[rd_line];
    end else begin : g_none
      // No storage: every line behaves as permanently overflowed.
      assign rd_ptr   = '0;
      assign rd_vld   = '0;
      assign rd_bcast = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/dirlp_sharer_update.sv
module dirlp_sharer_update #(
  parameter int NUM_NODES = 8,
  parameter int NUM_PTRS  = 2
) (
  input  logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0][$clog2(NUM_NODES)-1:0] cur_ptr,
  input  logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0] cur_vld,
  input  logic                                cur_bcast,
  input  logic [$clog2(NUM_NODES)-1:0]        node,
  input  logic                                is_write,
  output logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0][$clog2(NUM_NODES)-1:0] nxt_ptr,
  output logic [((NUM_PTRS>0)?NUM_PTRS:1)-1:0] nxt_vld,
  output logic                                nxt_bcast,
  output logic [NUM_NODES-1:0]                tgt_mask
);

  localparam int NODE_W = $clog2(NUM_NODES);
  localparam int SLOTS  = (NUM_PTRS > 0) ? NUM_PTRS : 1;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              hit;
  logic              free_found;
  logic [SLOT_W-1:0] free_idx;

  // Lookup: is the node already recorded, and which slot is free first.
  always_comb begin
    hit        = 1'b0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (cur_vld[s] && (cur_ptr[s] == node)) hit = 1'b1;
      if (!cur_vld[s] && !free_found) begin
        free_found = 1'b1;
        free_idx   = SLOT_W'(s);
      end
    end
  end

  // Target set: all nodes on overflow, else the recorded ones; never the requester.
  always_comb begin
    tgt_mask = '0;
    if (cur_bcast) begin
      tgt_mask = '1;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (cur_vld[s]) tgt_mask[cur_ptr[s]] = 1'b1;
      end
    end
    tgt_mask[node] = 1'b0;
  end

  // Next entry contents.
  always_comb begin
    nxt_ptr   = cur_ptr;
    nxt_vld   = cur_vld;
    nxt_bcast = cur_bcast;
    if (is_write) begin
      nxt_ptr    = '0;
      nxt_vld    = '0;
      nxt_ptr[0] = node;
      nxt_vld[0] = 1'b1;
      nxt_bcast  = 1'b0;
    end else if (!cur_bcast && !hit) begin
      if (free_found) begin
        nxt_ptr[free_idx] = node;
        nxt_vld[free_idx] = 1'b1;
      end else begin
        nxt_bcast = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dirlp_fanout.sv
module dirlp_fanout #(
  parameter int NUM_NODES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NUM_NODES-1:0]         load_mask,
  output logic                         msg_valid,
  input  logic                         msg_ready,
  output logic [$clog2(NUM_NODES)-1:0] msg_node,
  output logic                         empty
);

  localparam int NODE_W = $clog2(NUM_NODES);

  logic [NUM_NODES-1:0] mask_q;
  logic [NUM_NODES-1:0] mask_d;
  logic                 mask_en;
  logic [NUM_NODES-1:0] mask_drained;
  logic [NODE_W-1:0]    pick;
  logic                 pick_found;

  // Lowest pending node goes first.
  always_comb begin
    pick       = '0;
    pick_found = 1'b0;
    for (int n = 0; n < NUM_NODES; n++) begin
      if (mask_q[n] && !pick_found) begin
        pick_found = 1'b1;
        pick       = NODE_W'(n);
      end
    end
  end

  always_comb begin
    mask_drained       = mask_q;
    mask_drained[pick] = 1'b0;
    mask_en            = load | (msg_valid & msg_ready);
    mask_d             = load ? load_mask : mask_drained;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign msg_valid = pick_found;
  assign msg_node  = pick;
  assign empty     = ~pick_found;

endmodule

// File: rtl/dirlp_directory.sv
module dirlp_directory
  import dirlp_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int NUM_PTRS  = 2,
  parameter int NUM_LINES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [$clog2(NUM_LINES)-1:0] req_line,
  input  logic [$clog2(NUM_NODES)-1:0] req_node,
  output logic                         msg_valid,
  input  logic                         msg_ready,
  output logic [$clog2(NUM_NODES)-1:0] msg_node,
  output logic                         fan_done
);

  localparam int NODE_W = $clog2(NUM_NODES);
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int SLOTS  = (NUM_PTRS > 0) ? NUM_PTRS : 1;

  dir_state_e        state_q, state_d;
  logic [LINE_W-1:0] line_q;
  logic [NODE_W-1:0] node_q;
  logic              cap_en;

  logic              req_fire;
  logic              fan_empty;

  logic [LINE_W-1:0] ent_line;
  logic [NODE_W-1:0] ent_node;
  logic              ent_write;

  logic [SLOTS-1:0][NODE_W-1:0] cur_ptr, nxt_ptr;
  logic [SLOTS-1:0]             cur_vld, nxt_vld;
  logic                         cur_bcast, nxt_bcast;
  logic [NUM_NODES-1:0]         tgt_mask;
  logic                         store_en;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid & req_ready;
  assign fan_done  = (state_q == ST_FAN) & fan_empty;
  assign cap_en    = req_fire & req_write;

  // While fanning out, the entry being finished is the captured one.
  always_comb begin
    ent_line  = (state_q == ST_FAN) ? line_q : req_line;
    ent_node  = (state_q == ST_FAN) ? node_q : req_node;
    ent_write = (state_q == ST_FAN) ? 1'b1   : req_write;
    store_en  = (req_fire & ~req_write) | fan_done;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (cap_en)    state_d = ST_FAN;
      ST_FAN:  if (fan_empty) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      node_q <= '0;
    end else if (cap_en) begin
      line_q <= req_line;
      node_q <= req_node;
    end
  end

  dirlp_entry_store #(
    .NUM_NODES(NUM_NODES), .NUM_PTRS(NUM_PTRS), .NUM_LINES(NUM_LINES)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_line  (ent_line),
    .rd_ptr   (cur_ptr),
    .rd_vld   (cur_vld),
    .rd_bcast (cur_bcast),
    .wr_en    (store_en),
    .wr_line  (ent_line),
    .wr_ptr   (nxt_ptr),
    .wr_vld   (nxt_vld),
    .wr_bcast (nxt_bcast)
  );

  dirlp_sharer_update #(
    .NUM_NODES(NUM_NODES), .NUM_PTRS(NUM_PTRS)
  ) u_update (
    .cur_ptr   (cur_ptr),
    .cur_vld   (cur_vld),
    .cur_bcast (cur_bcast),
    .node      (ent_node),
    .is_write  (ent_write),
    .nxt_ptr   (nxt_ptr),
    .nxt_vld   (nxt_vld),
    .nxt_bcast (nxt_bcast),
    .tgt_mask  (tgt_mask)
  );

  dirlp_fanout #(
    .NUM_NODES(NUM_NODES)
  ) u_fan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cap_en),
    .load_mask (tgt_mask),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_node  (msg_node),
    .empty     (fan_empty)
  );

endmodule

// File: rtl/dirlp_directory_chk.sv
module dirlp_directory_chk #(
  parameter int NUM_NODES = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         req_write,
  input logic [$clog2(NUM_NODES)-1:0] req_node,
  input logic                         msg_valid,
  input logic                         msg_ready,
  input logic [$clog2(NUM_NODES)-1:0] msg_node,
  input logic                         fan_done
);

  localparam int NODE_W = $clog2(NUM_NODES);

  logic [NODE_W-1:0] writer_q;
  logic [NODE_W-1:0] last_q;
  logic              seen_q;
  logic [NODE_W:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      writer_q <= '0;
      last_q   <= '0;
      seen_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (req_valid && req_ready && req_write) begin
      writer_q <= req_node;
      seen_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (msg_valid && msg_ready) begin
      last_q <= msg_node;
      seen_q <= 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_node));

  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && seen_q |-> msg_node > last_q);

  assert_skip_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_node != writer_q);

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid || fan_done) |-> !req_ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fan_done |=> !fan_done && req_ready);

  assert_fan_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fan_done |-> int'(cnt_q) <= NUM_NODES - 1);

endmodule

bind dirlp_directory dirlp_directory_chk #(.NUM_NODES(NUM_NODES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_node  (req_node),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_node  (msg_node),
  .fan_done  (fan_done)
);

// File: tb/tb_dirlp_directory.sv
module tb_dirlp_directory;

  localparam int CLK_PERIOD = 10;
  localparam int NODES = 8;
  localparam int PTRS  = 2;
  localparam int LINES = 16;
  localparam int WD_CYCLES = 150000;

  logic       clk;
  logic       rst_n;
  logic       req_write;
  logic [3:0] req_line;
  logic [2:0] req_node;
  logic       req_valid_a [2];
  logic       req_ready_a [2];
  logic       msg_valid_a [2];
  logic       msg_ready_a [2];
  logic [2:0] msg_node_a  [2];
  logic       done_a      [2];

  int checks = 0;
  int fails  = 0;

  logic [NODES-1:0] exp_set [LINES];
  bit               exp_bc  [LINES];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  dirlp_directory #(.NUM_NODES(NODES), .NUM_PTRS(PTRS), .NUM_LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid_a[0]), .req_ready(req_ready_a[0]),
    .req_write(req_write), .req_line(req_line), .req_node(req_node),
    .msg_valid(msg_valid_a[0]), .msg_ready(msg_ready_a[0]),
    .msg_node(msg_node_a[0]), .fan_done(done_a[0])
  );

  dirlp_directory #(.NUM_NODES(NODES), .NUM_PTRS(0), .NUM_LINES(LINES)) dut_zero (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid_a[1]), .req_ready(req_ready_a[1]),
    .req_write(req_write), .req_line(req_line), .req_node(req_node),
    .msg_valid(msg_valid_a[1]), .msg_ready(msg_ready_a[1]),
    .msg_node(msg_node_a[1]), .fan_done(done_a[1])
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Requirement model of one read on the two-slot instance.
  task automatic model_read(input int line, input int n);
    if (!exp_bc[line] && !exp_set[line][n]) begin
      if ($countones(exp_set[line]) < PTRS) exp_set[line][n] = 1'b1;
      else exp_bc[line] = 1'b1;
    end
  endtask

  task automatic do_read(input int sel, input int line, input int n);
    @(negedge clk);
    req_valid_a[sel] = 1'b1;
    req_write = 1'b0;
    req_line  = 4'(line);
    req_node  = 3'(n);
    @(posedge clk);
    #1 req_valid_a[sel] = 1'b0;
  endtask

  task automatic do_write(input int sel, input int line, input int w,
                          input logic [NODES-1:0] exp, input string tag);
    logic [NODES-1:0] got;
    int  last;
    int  prev;
    bit  stalled;
    bit  seen_done;
    logic [2:0] held;
    @(negedge clk);
    req_valid_a[sel] = 1'b1;
    req_write = 1'b1;
    req_line  = 4'(line);
    req_node  = 3'(w);
    @(posedge clk);
    #1 req_valid_a[sel] = 1'b0;
    got = '0; last = -1; prev = -1; stalled = 1'b0; seen_done = 1'b0; held = '0;
    for (int c = 0; c < 64 && !seen_done; c++) begin
      @(negedge clk);
      msg_ready_a[sel] = ((c % 3) != 1);
      #1;
      if (c == 0) check(!req_ready_a[sel], "R7 busy after accept", int'(req_ready_a[sel]), 0);
      if (done_a[sel]) begin
        seen_done = 1'b1;
        check(c == last + 1, "R7 done timing", c, last + 1);
        check(!msg_valid_a[sel], "R7 no target with done", int'(msg_valid_a[sel]), 0);
      end else begin
        if (stalled)
          check(msg_valid_a[sel] && msg_node_a[sel] == held, "R6 hold under stall",
                int'(msg_node_a[sel]), int'(held));
        stalled = 1'b0;
        if (msg_valid_a[sel]) begin
          if (msg_ready_a[sel]) begin
            check(int'(msg_node_a[sel]) > prev, "R6 ascending", int'(msg_node_a[sel]), prev + 1);
            prev = int'(msg_node_a[sel]);
            got[msg_node_a[sel]] = 1'b1;
            last = c;
          end else begin
            stalled = 1'b1;
            held = msg_node_a[sel];
          end
        end
      end
    end
    msg_ready_a[sel] = 1'b0;
    check(seen_done, "R7 done seen", int'(seen_done), 1);
    check(got == exp, tag, int'(got), int'(exp));
    check(!got[w], "R5 writer skipped", int'(got[w]), 0);
    @(negedge clk);
    #1;
    check(!done_a[sel] && req_ready_a[sel], "R7 single pulse then ready",
          int'({done_a[sel], req_ready_a[sel]}), 1);
  endtask

  // Model of a write: returns targets and leaves the writer recorded.
  function automatic logic [NODES-1:0] model_write(input int line, input int w);
    logic [NODES-1:0] t;
    t = exp_bc[line] ? '1 : exp_set[line];
    t[w] = 1'b0;
    exp_set[line] = '0;
    exp_set[line][w] = 1'b1;
    exp_bc[line] = 1'b0;
    return t;
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", WD_CYCLES, 0);
    finish_run();
  end

  initial begin
    logic [NODES-1:0] e;
    string tag;
    rst_n = 1'b0;
    req_write = 1'b0; req_line = '0; req_node = '0;
    for (int s = 0; s < 2; s++) begin
      req_valid_a[s] = 1'b0;
      msg_ready_a[s] = 1'b0;
    end
    for (int l = 0; l < LINES; l++) begin
      exp_set[l] = '0;
      exp_bc[l]  = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int s = 0; s < 2; s++) begin
      check(req_ready_a[s] && !msg_valid_a[s] && !done_a[s], "R1 reset outputs",
            int'({req_ready_a[s], msg_valid_a[s], done_a[s]}), 4);
    end
    // R1: fresh line has no targets.
    do_write(0, 15, 2, model_write(15, 2), "R1 empty entry");

    // Sweep all reader subsets on the two-slot instance.
    for (int r = 0; r < 256; r++) begin
      int line;
      int w;
      int first;
      bit dup;
      line = r % LINES;
      w = (r * 5 + 1) % NODES;
      first = -1;
      dup = 1'b0;
      for (int n = 0; n < NODES; n++) begin
        if (r[n]) begin
          if (first < 0) first = n;
          do_read(0, line, n);
          model_read(line, n);
        end
      end
      if ((r % 2 == 1) && first >= 0) begin
        dup = 1'b1;
        do_read(0, line, first);
        model_read(line, first);
      end
      if (exp_bc[line]) tag = "R4 broadcast targets";
      else if (dup)     tag = "R3 duplicate ignored";
      else              tag = "R2 recorded sharers";
      e = model_write(line, w);
      do_write(0, line, w, e, tag);
      e = model_write(line, (w + 3) % NODES);
      do_write(0, line, (w + 3) % NODES, e, "R8 writer recorded");
    end

    // R9: activity on neighbour lines does not disturb a line.
    do_read(0, 4, 2);  model_read(4, 2);
    do_read(0, 5, 3);  model_read(5, 3);
    do_read(0, 5, 6);  model_read(5, 6);
    do_read(0, 5, 7);  model_read(5, 7);
    e = model_write(5, 0);
    do_write(0, 5, 0, e, "R9 overflowed neighbour");
    e = model_write(4, 0);
    do_write(0, 4, 0, e, "R9 line independent");

    // R10: zero-slot instance always targets every other node.
    for (int w = 0; w < NODES; w++) begin
      do_read(1, w, (w + 1) % NODES);
      e = '1;
      e[w] = 1'b0;
      do_write(1, w, w, e, "R10 zero-slot fan-out");
    end

    finish_run();
  end

endmodule